// File: doc/BRIEF.md
# Programmable Interval Timer

A 16-bit down-counting interval timer that sits on a simple register bus with a 3-bit byte offset and 16-bit data. Software sets up a control word and a modulus, and the counter then steps down once per prescaled tick. A tick is the core clock divided by 2^(PRE+1), where PRE is a 4-bit field, so the divide ratio is 2 to 65536 core cycles. When the count runs out, it reloads from the current limit and raises a sticky event flag. A level interrupt is driven while that flag and the interrupt-enable bit are both set.

The timer has two wrap modes. In reload mode the limit is the modulus register. In free-run mode the limit is fixed at 0xFFFF. The overwrite bit chooses whether a modulus write also loads the live count at once. A control write that touches only the interrupt-enable or flag bits leaves the running count and its tick phase alone. Any other control write restarts the count. The debug and doze bits are stored and read back but have no effect.

Top module: `tick_timer`

## Requirements
- R1: After reset, reads at offsets 0, 2 and 4 all return 0x0000, the timer is stopped and irq_o is 0.
- R2: Reads at offset 0 return the control word, at offset 2 the modulus and at offset 4 the live count. The control layout is: en bit 0, rld bit 1, flag bit 2, ie bit 3, ovw bit 4, dbg bit 5, doze bit 6, PRE bits 11:8. All other control bits read 0. Offsets other than 0, 2 and 4 read 0x0000, and writes to them change nothing.
- R3: While en is 1, a tick occurs every 2^(PRE+1) core cycles, counted from the restart edge. Each tick lowers the count by one.
- R4: A tick that finds the count at 1 or 0 reloads the count from the current limit and sets the flag. In reload mode with modulus L, the count therefore cycles L, L-1, ..., 1.
- R5: When rld is 0, the limit is 0xFFFF.
- R6: irq_o is 1 exactly when both the flag and ie are 1.
- R7: Writing 1 to control bit 2 clears the flag. Writing 0 to it leaves the flag as it is. No write ever sets the flag.
- R8: A control write whose other fields equal the current ones, so that only ie and the flag change, leaves the count and the tick phase undisturbed.
- R9: Any other control write loads the count with the limit: the modulus if the new rld is 1, else 0xFFFF. It also restarts the prescaler. While en is 0 the count holds.
- R10: A write at offset 2 always clears the flag.
- R11: In reload mode, a modulus write sets the limit. With ovw 1, it also loads the count at once and restarts the prescaler. With ovw 0, the count runs on and the new limit is used at the next wrap.
- R12: In free-run mode, a modulus write with ovw 1 loads the count. With ovw 0 the count is unaffected. In both cases the wrap value stays 0xFFFF.
- R13: Writes at offset 4 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 3 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The checker watches several rules on every cycle:
- The flag only rises on a wrap.
- A modulus write leaves the flag clear.
- A stopped counter holds its value when no write arrives.
- A wrap reloads the limit.
- The limit is 0xFFFF whenever the timer is in free-run mode.

Some behaviour can only be shown by the bench's scenarios:
- The exact tick spacing for each prescaler value.
- The wrap period for each modulus.
- That an enable-only control write keeps the tick phase.
- The different effects of a modulus write under each mode-bit combination.

The bench sweeps PRE and the modulus over a small range and compares the live count against arithmetic on elapsed cycles.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PRE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_MOD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 3'd4;

  // bit positions are software-visible
  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_RLD  = 1;
  localparam int unsigned B_FLAG = 2;
  localparam int unsigned B_IE   = 3;
  localparam int unsigned B_OVW  = 4;
  localparam int unsigned B_DBG  = 5;
  localparam int unsigned B_DOZE = 6;
  localparam int unsigned B_PRE  = 8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ie;
    logic             flag;
    logic             rld;
    logic             en;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]   = c.en;
    w[B_RLD]  = c.rld;
    w[B_FLAG] = c.flag;
    w[B_IE]   = c.ie;
    w[B_OVW]  = c.ovw;
    w[B_DBG]  = c.dbg;
    w[B_DOZE] = c.doze;
    w[B_PRE +: PRE_W] = c.pre;
    return w;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] w);
    ctrl_t c;
    c.en   = w[B_EN];
    c.rld  = w[B_RLD];
    c.flag = w[B_FLAG];
    c.ie   = w[B_IE];
    c.ovw  = w[B_OVW];
    c.dbg  = w[B_DBG];
    c.doze = w[B_DOZE];
    c.pre  = w[B_PRE +: PRE_W];
    return c;
  endfunction
endpackage

// File: rtl/tick_timer_prescaler.sv
module tick_timer_prescaler #(
  parameter int unsigned PRE_W     = 4,
  parameter int unsigned BASE_LOG2 = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] pre_i,
  output logic             tick_o
);
  localparam int unsigned PS_W = BASE_LOG2 + (1 << PRE_W) - 1;

  logic [PS_W-1:0] cnt_q;
  logic [PS_W:0]   span;
  logic [PS_W-1:0] term;

  always_comb begin
    span   = {{PS_W{1'b0}}, 1'b1} << (32'(pre_i) + BASE_LOG2);
    term   = PS_W'(span - 1'b1);
    tick_o = run_i && !restart_i && (cnt_q == term);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i || !run_i)      cnt_q <= '0;
    else if (tick_o)                   cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             set_limit_i,
  input  logic [CNT_W-1:0] limit_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q, limit_q;

  assign wrap_o  = tick_i && !load_i && (count_q <= CNT_W'(1));
  assign count_o = count_q;
  assign limit_o = limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '0;
    else if (load_i)  count_q <= load_val_i;
    else if (wrap_o)  count_q <= limit_q;
    else if (tick_i)  count_q <= count_q - 1'b1;
  end

  // free-run wrap value out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          limit_q <= '1;
    else if (set_limit_i) limit_q <= limit_val_i;
  end
endmodule

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              restart_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              set_limit_o,
  output logic [DATA_W-1:0] limit_val_o
);
  ctrl_t             ctrl_q, ctrl_d, req;
  logic [DATA_W-1:0] mod_q;
  logic              wr_ctrl, wr_mod, light, heavy;
  logic [DATA_W-1:0] new_limit;

  always_comb begin
    wr_ctrl  = wr_en_i && (addr_i == OFS_CTRL);
    wr_mod   = wr_en_i && (addr_i == OFS_MOD);
    req      = ctrl_unpack(wdata_i);
    req.flag = ctrl_q.flag & ~wdata_i[B_FLAG];
    // only ie/flag moved: leave the counter running
    light = (req.en == ctrl_q.en) && (req.rld == ctrl_q.rld) &&
            (req.ovw == ctrl_q.ovw) && (req.dbg == ctrl_q.dbg) &&
            (req.doze == ctrl_q.doze) && (req.pre == ctrl_q.pre);
    heavy     = wr_ctrl && !light;
    new_limit = req.rld ? mod_q : '1;

    load_o      = heavy || (wr_mod && ctrl_q.ovw);
    load_val_o  = heavy ? new_limit : wdata_i;
    set_limit_o = heavy || (wr_mod && ctrl_q.rld);
    limit_val_o = heavy ? new_limit : wdata_i;
    restart_o   = load_o;

    ctrl_d = ctrl_q;
    if (wr_ctrl) ctrl_d = req;
    if (wr_mod)  ctrl_d.flag = 1'b0;
    if (wrap_i)  ctrl_d.flag = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mod_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_mod) mod_q <= wdata_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mod_o  = mod_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] mod_q, count, limit, load_val, limit_val;
  logic              restart, load, set_limit, tick, wrap;

  tick_timer_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .wrap_i      (wrap),
    .ctrl_o      (ctrl_q),
    .mod_o       (mod_q),
    .restart_o   (restart),
    .load_o      (load),
    .load_val_o  (load_val),
    .set_limit_o (set_limit),
    .limit_val_o (limit_val)
  );

  tick_timer_prescaler #(
    .PRE_W     (PRE_W),
    .BASE_LOG2 (BASE_LOG2)
  ) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (ctrl_q.en),
    .restart_i (restart),
    .pre_i     (ctrl_q.pre),
    .tick_o    (tick)
  );

  tick_timer_counter #(
    .CNT_W (DATA_W)
  ) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .load_i      (load),
    .load_val_i  (load_val),
    .set_limit_i (set_limit),
    .limit_val_i (limit_val),
    .count_o     (count),
    .limit_o     (limit),
    .wrap_o      (wrap)
  );

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = ctrl_pack(ctrl_q);
      OFS_MOD:  rdata_o = mod_q;
      OFS_CNT:  rdata_o = count;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = ctrl_q.flag && ctrl_q.ie;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic        flag_i,
  input logic        en_i,
  input logic        rld_i,
  input logic        wrap_i,
  input logic [15:0] count_i,
  input logic [15:0] limit_i
);
  // R10
  mod_wr_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd2 && !wrap_i) |=> !flag_i);

  // R7
  flag_only_from_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i && !wrap_i) |=> !flag_i);

  // R9
  stopped_count_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_en_i) |=> $stable(count_i));

  // R4
  wrap_reloads_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !wr_en_i) |=> (count_i == $past(limit_i)));

  // R5
  free_run_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rld_i |-> (limit_i == 16'hFFFF));
endmodule

bind tick_timer tick_timer_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .flag_i  (ctrl_q.flag),
  .en_i    (ctrl_q.en),
  .rld_i   (ctrl_q.rld),
  .wrap_i  (wrap),
  .count_i (count),
  .limit_i (limit)
);

// File: tb/test_tick_timer.sv
`timescale 1ns/1ps
module test_tick_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = 3'd0;
  logic [15:0] wdata_i = 16'h0;
  logic [15:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0 = 0;
  bit done = 0;

  localparam logic [15:0] EN = 16'h0001, RLD = 16'h0002, FLG = 16'h0004,
                          IE = 16'h0008, OVW = 16'h0010;

  tick_timer i_tick_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h (t=%0d)", req, got, exp, cyc - t0);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic wait_to(input int t);
    while (cyc - t0 < t) @(negedge clk_i);
  endtask

  function automatic logic [15:0] reload_cnt(int l, int m, int n);
    int ticks = m / n;
    return 16'(l - (ticks % l));
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c;
    int m;
    repeat (3) @(negedge clk_i);
    rd(3'd0, v); check("R1 ctrl", v, 16'h0);
    rd(3'd2, v); check("R1 mod", v, 16'h0);
    rd(3'd4, v); check("R1 count", v, 16'h0);
    check("R1 irq", {15'b0, irq_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: layout, reserved bits, unmapped offsets
    wr(3'd0, 16'hF0E0);
    rd(3'd0, v); check("R2 reserved/dbg/doze", v, 16'h0060);
    wr(3'd0, 16'h0F00);
    rd(3'd0, v); check("R2 pre field", v, 16'h0F00);
    wr(3'd0, 16'h0000);
    wr(3'd2, 16'hA5A5);
    wr(3'd6, 16'h1234);
    rd(3'd6, v); check("R2 unmapped read", v, 16'h0);
    rd(3'd2, v); check("R2 mod readback", v, 16'hA5A5);
    rd(3'd0, v); check("R2 ctrl after unmapped write", v, 16'h0);

    // R3 R4 R9: sweep prescaler and modulus in reload mode
    for (int pre = 0; pre < 3; pre++) begin
      for (int li = 0; li < 4; li++) begin
        int l, n;
        l = (li == 3) ? 5 : li + 1;
        n = 2 << pre;
        wr(3'd0, 16'h0);
        wr(3'd2, 16'(l));
        wr(3'd0, EN | RLD | 16'(pre << 8));
        t0 = cyc;
        for (int s = 0; s <= 2 * l * n + 1; s++) begin
          wait_to(s);
          m = cyc - t0;
          rd(3'd4, v);
          rd(3'd0, c);
          check("R3 R4 reload count", v, reload_cnt(l, m, n));
          check("R4 flag", {15'b0, c[2]}, {15'b0, ((m / n) >= l)});
        end
      end
    end

    // R5 free run from 0xFFFF
    wr(3'd0, 16'h0);
    wr(3'd0, EN);
    t0 = cyc;
    for (int s = 0; s < 12; s += 3) begin
      wait_to(s);
      m = cyc - t0;
      rd(3'd4, v); check("R5 free-run count", v, 16'(32'hFFFF - m / 2));
    end

    // R12 free-run modulus write with overwrite
    wr(3'd0, EN | OVW);
    wr(3'd2, 16'd3);
    t0 = cyc;
    rd(3'd4, v); check("R12 ovw load", v, 16'd3);
    wait_to(4);
    rd(3'd4, v); check("R12 count after 2 ticks", v, 16'd1);
    rd(3'd0, c); check("R12 flag before wrap", {15'b0, c[2]}, 16'h0);
    wait_to(6);
    rd(3'd4, v); check("R12 wraps to FFFF", v, 16'hFFFF);
    rd(3'd0, c); check("R4 flag on free-run wrap", {15'b0, c[2]}, 16'h1);

    // R12 without overwrite: count unaffected
    wr(3'd0, EN);
    t0 = cyc;
    wait_to(3);
    wr(3'd2, 16'd7);
    m = cyc - t0;
    rd(3'd4, v); check("R12 no-ovw count runs on", v, 16'(32'hFFFF - m / 2));
    rd(3'd2, v); check("R2 mod value", v, 16'd7);

    // R11 reload without overwrite
    wr(3'd0, 16'h0);
    wr(3'd2, 16'd5);
    wr(3'd0, EN | RLD);
    t0 = cyc;
    wait_to(3);
    wr(3'd2, 16'd2);
    rd(3'd4, v); check("R11 no-ovw keeps count", v, 16'd3);
    wait_to(9);
    rd(3'd4, v); check("R11 before wrap", v, 16'd1);
    wait_to(10);
    rd(3'd4, v); check("R11 new limit at wrap", v, 16'd2);
    wait_to(12);
    rd(3'd4, v); check("R11 next tick", v, 16'd1);
    wait_to(14);
    rd(3'd4, v); check("R11 second wrap", v, 16'd2);

    // R11 reload with overwrite
    wr(3'd0, 16'h0);
    wr(3'd2, 16'd5);
    wr(3'd0, EN | RLD | OVW);
    t0 = cyc;
    wait_to(3);
    wr(3'd2, 16'd2);
    t0 = cyc;
    rd(3'd4, v); check("R11 ovw immediate load", v, 16'd2);
    wait_to(2);
    rd(3'd4, v); check("R11 ovw prescaler restarted", v, 16'd1);
    wait_to(4);
    rd(3'd4, v); check("R11 ovw wrap", v, 16'd2);
    rd(3'd0, c); check("R4 ovw flag", {15'b0, c[2]}, 16'h1);

    // R8 R6 R7: interrupt-enable only writes
    wr(3'd0, 16'h0);
    wr(3'd2, 16'd5);
    wr(3'd0, EN | RLD);
    t0 = cyc;
    wait_to(3);
    wr(3'd0, EN | RLD | IE);
    for (int s = 4; s <= 10; s++) begin
      wait_to(s);
      rd(3'd4, v); check("R8 count undisturbed", v, reload_cnt(5, cyc - t0, 2));
    end
    check("R6 irq on flag and ie", {15'b0, irq_o}, 16'h1);
    wr(3'd0, EN | RLD);
    check("R6 irq off with ie 0", {15'b0, irq_o}, 16'h0);
    rd(3'd0, c); check("R7 write 0 keeps flag", {15'b0, c[2]}, 16'h1);
    wr(3'd0, EN | RLD | IE | FLG);
    rd(3'd0, c); check("R7 W1C clears flag", c, EN | RLD | IE);
    check("R6 irq after clear", {15'b0, irq_o}, 16'h0);
    wr(3'd0, EN | RLD | IE | FLG);
    rd(3'd0, c); check("R7 W1C cannot set", {15'b0, c[2]}, 16'h0);
    m = cyc - t0;
    rd(3'd4, v); check("R8 count after flag writes", v, reload_cnt(5, m, 2));

    // R10 modulus write clears flag
    wait_to(20);
    check("R6 irq second wrap", {15'b0, irq_o}, 16'h1);
    wr(3'd2, 16'd5);
    rd(3'd0, c); check("R10 mod write clears flag", {15'b0, c[2]}, 16'h0);
    check("R10 irq low", {15'b0, irq_o}, 16'h0);

    // R13 count offset writes ignored
    wr(3'd4, 16'h1234);
    m = cyc - t0;
    rd(3'd4, v); check("R13 count write ignored", v, reload_cnt(5, m, 2));

    // R9 restart when disabled, then hold
    wr(3'd0, RLD);
    rd(3'd4, v); check("R9 restart loads modulus", v, 16'd5);
    repeat (10) @(negedge clk_i);
    rd(3'd4, v); check("R9 disabled holds", v, 16'd5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule